// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block watches the register numbers and control bits held in the pipeline registers of a five-stage in-order processor. The five stages are fetch, decode, execute, memory and writeback. From those inputs it decides three things.

- Where each execute-stage ALU operand should come from: the register file, the memory-stage result or the writeback-stage result.
- Whether the two branch-comparator operands in decode should take the memory-stage result instead of the register-file value.
- Whether the front of the pipeline must hold for one cycle while a bubble is pushed into execute.

Every output is a pure combinational function of the present inputs. It is meant to sit beside the pipeline registers and drive their enables and clears directly. When the clear is applied, the execute register is loaded with all zeros, so the instruction behaves as a no-operation. When the holds are applied, the fetch and decode registers keep their contents. Nothing is bypassed from writeback into decode. The register file is assumed to write in the first half of a cycle and read in the second half, so decode already sees a value being written back in the same cycle.

Top module: `hazard_ctrl`

## Requirements
- R1: `byp_a_exe` is 2'b10 (take memory-stage result) when `rs_exe` is nonzero, equals `dst_mem`, and `wr_en_mem` is 1.
- R2: When R1 does not apply, `byp_a_exe` is 2'b01 (take writeback result) if `rs_exe` is nonzero, equals `dst_wb`, and `wr_en_wb` is 1. Otherwise it is 2'b00 (register file). A memory-stage match wins over a writeback match, and the code 2'b11 never appears.
- R3: `byp_b_exe` follows the rules of R1 and R2 with `rt_exe` in place of `rs_exe`.
- R4: A source register number of zero never produces a bypass, in either execute or decode, even if a producer writes register zero.
- R5: A load-use stall is raised when `load_exe` is 1 and `rt_exe` equals `rs_dec` or `rt_dec`.
- R6: `byp_a_dec` (or `byp_b_dec`) is 1 only when `rs_dec` (or `rt_dec`) is nonzero, equals `dst_mem`, and `wr_en_mem` is 1. A writeback-stage match alone leaves it 0.
- R7: A branch stall is raised when `branch_dec`, `wr_en_exe` are 1 and `dst_exe` equals `rs_dec` or `rt_dec`.
- R8: A branch stall is raised when `branch_dec`, `load_mem` are 1 and `dst_mem` equals `rs_dec` or `rt_dec`.
- R9: `hold_fetch`, `hold_decode` and `clear_exe` are always equal to each other, and equal to the OR of the load-use stall and the branch stall. They are 0 when neither stall applies, including a register match with `branch_dec` at 0.
- R10: When a load-use stall and a branch stall occur in the same cycle, the three stall outputs stay a single 1. The bypass selects are computed in that cycle exactly as they would be without a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_dec | input | 5 | First source register in decode |
| rt_dec | input | 5 | Second source register in decode |
| branch_dec | input | 1 | Decode holds a conditional branch |
| rs_exe | input | 5 | First source register in execute |
| rt_exe | input | 5 | Second source register in execute (load destination) |
| dst_exe | input | 5 | Destination register in execute |
| wr_en_exe | input | 1 | Execute instruction writes a register |
| load_exe | input | 1 | Execute instruction is a load |
| dst_mem | input | 5 | Destination register in memory stage |
| wr_en_mem | input | 1 | Memory-stage instruction writes a register |
| load_mem | input | 1 | Memory-stage instruction is a load |
| dst_wb | input | 5 | Destination register in writeback |
| wr_en_wb | input | 1 | Writeback instruction writes a register |
| byp_a_exe | output | 2 | Execute operand A source select |
| byp_b_exe | output | 2 | Execute operand B source select |
| byp_a_dec | output | 1 | Branch operand A takes memory-stage result |
| byp_b_dec | output | 1 | Branch operand B takes memory-stage result |
| hold_fetch | output | 1 | Hold the fetch register |
| hold_decode | output | 1 | Hold the decode register |
| clear_exe | output | 1 | Zero the execute register |

## Verification
Two functions can fall in the same cycle: the stall decision and the bypass selection. The bench sets up a load in execute whose target matches a decode source while a branch in decode also waits on the execute result. In that same cycle it places a memory-stage producer that matches both a decode source and an execute source. It then checks that the three stall outputs are a single clean 1, and that both the decode and execute bypass selects take the values the bypass rules alone would give.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Source select for an execute-stage ALU operand
    typedef enum logic [1:0] {
        BYP_RF  = 2'b00,
        BYP_WB  = 2'b01,
        BYP_MEM = 2'b10
    } byp_sel_e;

    // Pipeline control produced by the stall logic
    typedef struct packed {
        logic hold_fetch;
        logic hold_decode;
        logic clear_exe;
    } stall_ctl_t;

endpackage

// File: rtl/hz_exe_byp.sv
module hz_exe_byp
    import hzd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst_mem,
    input  logic             wr_mem,
    input  logic [REG_W-1:0] dst_wb,
    input  logic             wr_wb,
    output byp_sel_e         sel
);

    logic     src_live_d;
    byp_sel_e sel_d;

    always_comb begin
        src_live_d = (src != '0);
        sel_d      = BYP_RF;
        // newest producer first: memory stage beats writeback
        if (src_live_d && wr_mem && (src == dst_mem)) begin
            sel_d = BYP_MEM;
        end else if (src_live_d && wr_wb && (src == dst_wb)) begin
            sel_d = BYP_WB;
        end
    end

    assign sel = sel_d;

endmodule

// File: rtl/hz_dec_byp.sv
module hz_dec_byp #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst_mem,
    input  logic             wr_mem,
    output logic             take_mem
);

    logic take_d;

    // writeback needs no path: register file writes before it reads
    always_comb begin
        take_d = (src != '0) && wr_mem && (src == dst_mem);
    end

    assign take_mem = take_d;

endmodule

// File: rtl/hz_stall.sv
module hz_stall
    import hzd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] rs_dec,
    input  logic [REG_W-1:0] rt_dec,
    input  logic             branch_dec,
    input  logic [REG_W-1:0] rt_exe,
    input  logic             load_exe,
    input  logic [REG_W-1:0] dst_exe,
    input  logic             wr_en_exe,
    input  logic [REG_W-1:0] dst_mem,
    input  logic             load_mem,
    output stall_ctl_t       ctl
);

    logic       load_use_d;
    logic       br_exe_d;
    logic       br_mem_d;
    logic       stall_d;
    stall_ctl_t ctl_d;

    always_comb begin
        load_use_d = load_exe && ((rs_dec == rt_exe) || (rt_dec == rt_exe));
        br_exe_d   = branch_dec && wr_en_exe &&
                     ((dst_exe == rs_dec) || (dst_exe == rt_dec));
        br_mem_d   = branch_dec && load_mem &&
                     ((dst_mem == rs_dec) || (dst_mem == rt_dec));
        stall_d    = load_use_d || br_exe_d || br_mem_d;

        ctl_d.hold_fetch  = stall_d;
        ctl_d.hold_decode = stall_d;
        ctl_d.clear_exe   = stall_d;
    end

    assign ctl = ctl_d;

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hzd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] rs_dec,
    input  logic [REG_W-1:0] rt_dec,
    input  logic             branch_dec,
    input  logic [REG_W-1:0] rs_exe,
    input  logic [REG_W-1:0] rt_exe,
    input  logic [REG_W-1:0] dst_exe,
    input  logic             wr_en_exe,
    input  logic             load_exe,
    input  logic [REG_W-1:0] dst_mem,
    input  logic             wr_en_mem,
    input  logic             load_mem,
    input  logic [REG_W-1:0] dst_wb,
    input  logic             wr_en_wb,
    output logic [1:0]       byp_a_exe,
    output logic [1:0]       byp_b_exe,
    output logic             byp_a_dec,
    output logic             byp_b_dec,
    output logic             hold_fetch,
    output logic             hold_decode,
    output logic             clear_exe
);

    localparam int NUM_SRC = 2;

    logic [REG_W-1:0] exe_src [NUM_SRC];
    logic [REG_W-1:0] dec_src [NUM_SRC];
    byp_sel_e         exe_sel [NUM_SRC];
    logic             dec_take [NUM_SRC];
    stall_ctl_t       ctl;

    assign exe_src[0] = rs_exe;
    assign exe_src[1] = rt_exe;
    assign dec_src[0] = rs_dec;
    assign dec_src[1] = rt_dec;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        hz_exe_byp #(.REG_W(REG_W)) u_exe_byp (
            .src     (exe_src[i]),
            .dst_mem (dst_mem),
            .wr_mem  (wr_en_mem),
            .dst_wb  (dst_wb),
            .wr_wb   (wr_en_wb),
            .sel     (exe_sel[i])
        );
        hz_dec_byp #(.REG_W(REG_W)) u_dec_byp (
            .src      (dec_src[i]),
            .dst_mem  (dst_mem),
            .wr_mem   (wr_en_mem),
            .take_mem (dec_take[i])
        );
    end

    hz_stall #(.REG_W(REG_W)) u_stall (
        .rs_dec     (rs_dec),
        .rt_dec     (rt_dec),
        .branch_dec (branch_dec),
        .rt_exe     (rt_exe),
        .load_exe   (load_exe),
        .dst_exe    (dst_exe),
        .wr_en_exe  (wr_en_exe),
        .dst_mem    (dst_mem),
        .load_mem   (load_mem),
        .ctl        (ctl)
    );

    assign byp_a_exe   = exe_sel[0];
    assign byp_b_exe   = exe_sel[1];
    assign byp_a_dec   = dec_take[0];
    assign byp_b_dec   = dec_take[1];
    assign hold_fetch  = ctl.hold_fetch;
    assign hold_decode = ctl.hold_decode;
    assign clear_exe   = ctl.clear_exe;

    // Checks on settled outputs, skipped while any input is still unknown
    always_comb begin
        if (!$isunknown({rs_dec, rt_dec, branch_dec, rs_exe, rt_exe, dst_exe,
                         wr_en_exe, load_exe, dst_mem, wr_en_mem, load_mem,
                         dst_wb, wr_en_wb})) begin
            // R2
            sel_code_legal_chk: assert (byp_a_exe != 2'b11 && byp_b_exe != 2'b11);
            // R1
            mem_byp_source_chk: assert (byp_a_exe != 2'b10 || (wr_en_mem && dst_mem == rs_exe));
            // R4
            zero_src_exe_chk: assert ((rs_exe != '0 || byp_a_exe == 2'b00) &&
                                      (rt_exe != '0 || byp_b_exe == 2'b00));
            // R4
            zero_src_dec_chk: assert ((rs_dec != '0 || !byp_a_dec) &&
                                      (rt_dec != '0 || !byp_b_dec));
            // R6
            dec_byp_needs_mem_chk: assert (!(byp_a_dec || byp_b_dec) || wr_en_mem);
            // R9
            stall_cause_chk: assert (!hold_fetch || load_exe || branch_dec);
            // R9
            stall_agree_chk: assert (hold_fetch == hold_decode && hold_decode == clear_exe);
        end
    end

endmodule

// File: tb/hazard_ctrl_bench.sv
module hazard_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] rs_dec, rt_dec, rs_exe, rt_exe, dst_exe, dst_mem, dst_wb;
    logic       branch_dec, wr_en_exe, load_exe, wr_en_mem, load_mem, wr_en_wb;
    logic [1:0] byp_a_exe, byp_b_exe;
    logic       byp_a_dec, byp_b_dec, hold_fetch, hold_decode, clear_exe;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_ctrl u_hazard_ctrl (
        .rs_dec(rs_dec), .rt_dec(rt_dec), .branch_dec(branch_dec),
        .rs_exe(rs_exe), .rt_exe(rt_exe), .dst_exe(dst_exe),
        .wr_en_exe(wr_en_exe), .load_exe(load_exe),
        .dst_mem(dst_mem), .wr_en_mem(wr_en_mem), .load_mem(load_mem),
        .dst_wb(dst_wb), .wr_en_wb(wr_en_wb),
        .byp_a_exe(byp_a_exe), .byp_b_exe(byp_b_exe),
        .byp_a_dec(byp_a_dec), .byp_b_dec(byp_b_dec),
        .hold_fetch(hold_fetch), .hold_decode(hold_decode), .clear_exe(clear_exe)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        rs_dec = 0; rt_dec = 0; branch_dec = 0;
        rs_exe = 0; rt_exe = 0; dst_exe = 0; wr_en_exe = 0; load_exe = 0;
        dst_mem = 0; wr_en_mem = 0; load_mem = 0;
        dst_wb = 0; wr_en_wb = 0;
    endtask

    // let inputs settle, sample half a period later
    task automatic settle();
        @(negedge clk);
    endtask

    // all three stall outputs checked together (R9)
    task automatic chk_stall(input string req, input int exp);
        chk(req, "hold_fetch", hold_fetch, exp);
        chk("R9", "hold_decode", hold_decode, exp);
        chk("R9", "clear_exe", clear_exe, exp);
    endtask

    task automatic t_reset_state();
        idle(); settle();
        chk("R9", "idle byp_a_exe", byp_a_exe, 0);
        chk("R9", "idle byp_b_exe", byp_b_exe, 0);
        chk("R9", "idle byp_a_dec", byp_a_dec, 0);
        chk("R9", "idle byp_b_dec", byp_b_dec, 0);
        chk_stall("R9", 0);
    endtask

    task automatic t_mem_bypass();
        idle(); rs_exe = 5; rt_exe = 6; dst_mem = 5; wr_en_mem = 1; settle();
        chk("R1", "mem match A", byp_a_exe, 2);
        chk("R1", "no match B", byp_b_exe, 0);
        wr_en_mem = 0; settle();
        chk("R1", "no write A", byp_a_exe, 0);
    endtask

    task automatic t_wb_priority();
        idle(); rs_exe = 7; dst_wb = 7; wr_en_wb = 1; settle();
        chk("R2", "wb match A", byp_a_exe, 1);
        dst_mem = 7; wr_en_mem = 1; settle();
        chk("R2", "mem beats wb", byp_a_exe, 2);
        wr_en_mem = 0; settle();
        chk("R2", "mem not writing", byp_a_exe, 1);
        wr_en_wb = 0; settle();
        chk("R2", "neither writing", byp_a_exe, 0);
    endtask

    task automatic t_operand_b();
        idle(); rs_exe = 3; rt_exe = 9; dst_mem = 9; wr_en_mem = 1; settle();
        chk("R3", "mem match B", byp_b_exe, 2);
        chk("R3", "A untouched", byp_a_exe, 0);
        wr_en_mem = 0; dst_wb = 9; wr_en_wb = 1; settle();
        chk("R3", "wb match B", byp_b_exe, 1);
    endtask

    task automatic t_zero_reg();
        idle(); dst_mem = 0; wr_en_mem = 1; dst_wb = 0; wr_en_wb = 1; settle();
        chk("R4", "zero A exe", byp_a_exe, 0);
        chk("R4", "zero B exe", byp_b_exe, 0);
        chk("R4", "zero A dec", byp_a_dec, 0);
        chk("R4", "zero B dec", byp_b_dec, 0);
    endtask

    task automatic t_load_use();
        idle(); load_exe = 1; rt_exe = 4; rs_dec = 4; rt_dec = 2; settle();
        chk_stall("R5", 1);
        rs_dec = 2; rt_dec = 4; settle();
        chk_stall("R5", 1);
        rt_dec = 3; settle();
        chk_stall("R5", 0);
        rt_dec = 4; load_exe = 0; settle();
        chk_stall("R5", 0);
    endtask

    task automatic t_dec_bypass();
        idle(); rs_dec = 8; rt_dec = 1; dst_mem = 8; wr_en_mem = 1; settle();
        chk("R6", "dec A mem", byp_a_dec, 1);
        chk("R6", "dec B none", byp_b_dec, 0);
        rs_dec = 1; rt_dec = 8; settle();
        chk("R6", "dec B mem", byp_b_dec, 1);
        wr_en_mem = 0; dst_wb = 8; wr_en_wb = 1; settle();
        chk("R6", "wb only no dec byp", byp_b_dec, 0);
    endtask

    task automatic t_branch_exe();
        idle(); branch_dec = 1; wr_en_exe = 1; dst_exe = 10; rs_dec = 10; rt_dec = 2; settle();
        chk_stall("R7", 1);
        rs_dec = 2; rt_dec = 10; settle();
        chk_stall("R7", 1);
        wr_en_exe = 0; settle();
        chk_stall("R7", 0);
        wr_en_exe = 1; branch_dec = 0; settle();
        chk_stall("R9", 0);
    endtask

    task automatic t_branch_mem();
        idle(); branch_dec = 1; load_mem = 1; dst_mem = 11; rt_dec = 11; rs_dec = 2; settle();
        chk_stall("R8", 1);
        chk("R8", "no dec byp without write", byp_b_dec, 0);
        load_mem = 0; settle();
        chk_stall("R8", 0);
    endtask

    task automatic t_overlap();
        idle();
        load_exe = 1; rt_exe = 12; rs_dec = 12;
        branch_dec = 1; wr_en_exe = 1; dst_exe = 12;
        rt_dec = 13; rs_exe = 13; dst_mem = 13; wr_en_mem = 1;
        settle();
        chk_stall("R10", 1);
        chk("R10", "dec B byp under stall", byp_b_dec, 1);
        chk("R10", "exe A byp under stall", byp_a_exe, 2);
        chk("R10", "exe B no byp", byp_b_exe, 0);
    endtask

    initial begin
        idle();
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_mem_bypass();
        t_wb_priority();
        t_operand_b();
        t_zero_reg();
        t_load_use();
        t_dec_bypass();
        t_branch_exe();
        t_branch_mem();
        t_overlap();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule